// File: doc/BRIEF.md
# Masked System Control Register Bank

This block is a small bank of memory-mapped control registers on a 32-bit bus. Software addresses it with a byte address and a transfer size of byte, 16-bit word or 32-bit longword. It holds a halt code register, a DMA map base register, a diagnostic display register, a parity control register, a secondary cache control register and a diagnostic timer.

Each register has its own write mask and its own read mask. A write first merges the incoming data into the addressed byte lanes of the current value. The register's write mask then decides which of the merged bits are stored. A read returns the stored value ANDed with the read mask, one cycle after the request. The diagnostic timer is a 16-bit count that moves forward by a fixed step each time it is read. A read returns the new count in both halves of the word.

Top module: `scr_bank`

## Requirements
- R1: A synchronous active-high reset clears every register except parity control, which reads 0x000000F0 afterwards. The reset also drives `rd_valid` low.
- R2: A read request asserted at a clock edge gives `rd_valid` high and `rd_data` for exactly the following cycle. When `wr_en` and `rd_en` are both high, only the write is performed: `rd_valid` stays low and the timer does not advance.
- R3: The halt code register at word offset 0, the DMA map base register at word offset 2 and the diagnostic display register at word offset 4 are plain 32-bit read/write registers.
- R4: Parity control sits at word offset 5. A write changes only the bits in 0x01010101. A read returns the stored value ANDed with 0x830707F1. Bits 7:4 always read 0xF.
- R5: Cache control sits at word offset 6. It stores only the bits in 0x00000101 and exposes only the bits in 0x00000783 on reads.
- R6: Size code 0 means byte, 1 means 16-bit word and 2 or 3 means longword. For a byte or word write, the low 8 or 16 data bits are shifted left by 8 times `addr[1:0]`, and only those lanes of the current value are replaced before the write mask is applied. A longword write ignores `addr[1:0]`.
- R7: The diagnostic timer sits at word offset 7. Each read first adds 5 to the 16-bit count, wrapping modulo 65536, and then returns the new count in both bits 31:16 and bits 15:0.
- R8: A write to the timer loads the count from bits 31:16 of the lane-merged write data. A byte or word write that covers only lanes 0 and 1 leaves the count unchanged.
- R9: Reads of the unimplemented word offsets 1 and 3 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | 5 | Byte address: bits 4:2 select the word offset, bits 1:0 select the lane |
| size | input | 2 | Transfer size: 0 byte, 1 word, 2 or 3 longword |
| wdata | input | 32 | Write data, right justified |
| rd_valid | output | 1 | Read data valid, one cycle after the read request |
| rd_data | output | 32 | Registered read data |

## Verification
Longword writes of all ones show the write and read masks apart. After such a write, parity control reads 0x010101F1 and cache control reads 0x00000101, so a swapped or missing mask gives a different value. Byte and word writes at each lane offset into a register with a known background pattern show whether the shift and the lane replacement are right. Timer loads through the upper half, a lane-0 byte write, a load near the 16-bit limit, and back-to-back reads separate pre-increment from post-increment, confirm the wrap, and confirm that low-lane writes are ignored. A simultaneous read and write shows that the write has priority.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int DATA_W   = 32;
  localparam int TMR_W    = 16;
  localparam int TMR_STEP = 5;

  localparam int OFF_HALT = 0;
  localparam int OFF_MAPB = 2;
  localparam int OFF_DISP = 4;
  localparam int OFF_PAR  = 5;
  localparam int OFF_CCR  = 6;
  localparam int OFF_TMR  = 7;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LNG2 = 2'd3
  } xfer_size_e;

  function automatic logic [DATA_W-1:0] wr_mask(input int off);
    case (off)
      OFF_HALT, OFF_MAPB, OFF_DISP: return 32'hFFFF_FFFF;
      OFF_PAR:                      return 32'h0101_0101;
      OFF_CCR:                      return 32'h0000_0101;
      default:                      return 32'h0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rd_mask(input int off);
    case (off)
      OFF_HALT, OFF_MAPB, OFF_DISP: return 32'hFFFF_FFFF;
      OFF_PAR:                      return 32'h8307_07F1;
      OFF_CCR:                      return 32'h0000_0783;
      default:                      return 32'h0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rst_val(input int off);
    return (off == OFF_PAR) ? 32'h0000_00F0 : 32'h0;
  endfunction

  function automatic bit is_masked_reg(input int off);
    return (off == OFF_HALT) || (off == OFF_MAPB) || (off == OFF_DISP) ||
           (off == OFF_PAR)  || (off == OFF_CCR);
  endfunction
endpackage

// File: rtl/scr_lane_merge.sv
module scr_lane_merge
  import scr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   lane,
  input  logic [1:0]   size,
  output logic [W-1:0] merged
);
  logic [W-1:0] base_mask;
  logic [W-1:0] lane_mask;
  logic [W-1:0] lane_data;
  logic [4:0]   shamt;

  always_comb begin
    shamt = {lane, 3'b000};
    case (xfer_size_e'(size))
      SZ_BYTE: base_mask = W'(32'h0000_00FF);
      SZ_WORD: base_mask = W'(32'h0000_FFFF);
      default: base_mask = '1;
    endcase
    if (size[1]) begin
      lane_mask = '1;
      lane_data = wdata;
    end else begin
      lane_mask = base_mask << shamt;
      lane_data = (wdata & base_mask) << shamt;
    end
    merged = (cur & ~lane_mask) | (lane_data & lane_mask);
  end
endmodule

// File: rtl/scr_masked_reg.sv
module scr_masked_reg
  import scr_pkg::*;
#(
  parameter int          W     = DATA_W,
  parameter logic [31:0] RST   = 32'h0,
  parameter logic [31:0] WMASK = 32'hFFFF_FFFF,
  parameter logic [31:0] RMASK = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   lane,
  input  logic [1:0]   size,
  output logic [W-1:0] rd_val
);
  localparam logic [W-1:0] WM = W'(WMASK);
  localparam logic [W-1:0] RM = W'(RMASK);
  localparam logic [W-1:0] RV = W'(RST);

  logic [W-1:0] cur_q;
  logic [W-1:0] merged;

  scr_lane_merge #(.W(W)) u_merge (
    .cur    (cur_q),
    .wdata  (wdata),
    .lane   (lane),
    .size   (size),
    .merged (merged)
  );

  always_ff @(posedge clk) begin
    if (rst)     cur_q <= RV;
    else if (we) cur_q <= (cur_q & ~WM) | (merged & WM);
  end

  assign rd_val = cur_q & RM;
endmodule

// File: rtl/scr_diag_timer.sv
module scr_diag_timer
  import scr_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int CW   = TMR_W,
  parameter int STEP = TMR_STEP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         re,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   lane,
  input  logic [1:0]   size,
  output logic [W-1:0] rd_val
);
  localparam int LO_W = W - CW;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic [W-1:0]  image;
  logic [W-1:0]  merged;
  logic          unused_lo;

  assign image   = {cnt_q, {LO_W{1'b0}}};
  assign cnt_nxt = cnt_q + CW'(STEP);

  scr_lane_merge #(.W(W)) u_merge (
    .cur    (image),
    .wdata  (wdata),
    .lane   (lane),
    .size   (size),
    .merged (merged)
  );

  assign unused_lo = ^merged[LO_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (we) cnt_q <= merged[W-1 -: CW];
    else if (re) cnt_q <= cnt_nxt;
  end

  assign rd_val = {cnt_nxt, cnt_nxt};
endmodule

// File: rtl/scr_bank.sv
module scr_bank
  import scr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W+1:0]   addr,
  input  logic [1:0]          size,
  input  logic [DATA_W-1:0]   wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int NUM_OFFS = 1 << ADDR_W;

  logic [ADDR_W-1:0] off;
  logic [1:0]        lane;
  logic              do_rd;
  logic [DATA_W-1:0] rd_vec [NUM_OFFS];

  assign off   = addr[ADDR_W+1:2];
  assign lane  = addr[1:0];
  assign do_rd = rd_en && !wr_en;

  for (genvar i = 0; i < NUM_OFFS; i++) begin : g_off
    logic hit;
    assign hit = (off == ADDR_W'(i));
    if (is_masked_reg(i)) begin : g_reg
      scr_masked_reg #(
        .W     (DATA_W),
        .RST   (rst_val(i)),
        .WMASK (wr_mask(i)),
        .RMASK (rd_mask(i))
      ) u_reg (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en && hit),
        .wdata  (wdata),
        .lane   (lane),
        .size   (size),
        .rd_val (rd_vec[i])
      );
    end else if (i == OFF_TMR) begin : g_tmr
      scr_diag_timer #(
        .W    (DATA_W),
        .CW   (TMR_W),
        .STEP (TMR_STEP)
      ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en && hit),
        .re     (do_rd && hit),
        .wdata  (wdata),
        .lane   (lane),
        .size   (size),
        .rd_val (rd_vec[i])
      );
    end else begin : g_none
      logic unused_hit;
      assign unused_hit = hit;
      assign rd_vec[i]  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= rd_vec[off];
    end
  end
endmodule

// File: rtl/scr_bank_chk.sv
module scr_bank_chk
  import scr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W+1:0] addr,
  input logic [1:0]        size,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] off;
  assign off = addr[ADDR_W+1:2];

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> !rd_valid);

  a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && !wr_en));

  a_r2_read_gives_valid: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> rd_valid);

  a_r4_parity_read_mask: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(off) == ADDR_W'(OFF_PAR)) |->
      ((rd_data & ~32'h8307_07F1) == 32'h0 && rd_data[7:4] == 4'hF));

  a_r5_cache_read_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(off) == ADDR_W'(OFF_CCR)) |->
      ((rd_data & ~32'h0000_0101) == 32'h0));

  a_r7_timer_halves: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(off) == ADDR_W'(OFF_TMR)) |->
      (rd_data[31:16] == rd_data[15:0]));

  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ($past(off) == ADDR_W'(1) || $past(off) == ADDR_W'(3))) |->
      (rd_data == 32'h0));

  logic unused_chk;
  assign unused_chk = ^{size, wdata};
endmodule

bind scr_bank scr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_scr_bank.sv
`timescale 1ns/1ps
module tb_scr_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [1:0]  size;
  logic [31:0] wdata;
  logic        rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  scr_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [4:0] ba(input int off, input int ln);
    return 5'((off << 2) | ln);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    addr = a; size = sz; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d; logic v;
    rd(a, d, v);
    check({req, " valid"}, {31'b0, v}, 32'h1);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R1 rd_valid low", {31'b0, rd_valid}, 32'h0);
    rd_chk("R1 halt", ba(0, 0), 32'h0);
    rd_chk("R1 mapbase", ba(2, 0), 32'h0);
    rd_chk("R1 display", ba(4, 0), 32'h0);
    rd_chk("R1 parity", ba(5, 0), 32'h0000_00F0);
    rd_chk("R1 cache", ba(6, 0), 32'h0);
    rd_chk("R1 R7 timer first read", ba(7, 0), 32'h0005_0005);
  endtask

  task automatic t_plain;
    wr(ba(0, 0), 2'd2, 32'hDEAD_BEEF);
    wr(ba(2, 0), 2'd2, 32'h0012_3000);
    wr(ba(4, 0), 2'd2, 32'hA5A5_5A5A);
    rd_chk("R3 halt", ba(0, 0), 32'hDEAD_BEEF);
    rd_chk("R3 mapbase", ba(2, 0), 32'h0012_3000);
    rd_chk("R3 display", ba(4, 0), 32'hA5A5_5A5A);
  endtask

  task automatic t_parity;
    wr(ba(5, 0), 2'd2, 32'hFFFF_FFFF);
    rd_chk("R4 parity all ones", ba(5, 0), 32'h0101_01F1);
    wr(ba(5, 0), 2'd2, 32'h0000_0000);
    rd_chk("R4 parity cleared, revision kept", ba(5, 0), 32'h0000_00F0);
    wr(ba(5, 2), 2'd0, 32'h0000_00FF);
    rd_chk("R4 R6 parity byte lane 2", ba(5, 0), 32'h0001_00F0);
  endtask

  task automatic t_cache;
    wr(ba(6, 0), 2'd2, 32'hFFFF_FFFF);
    rd_chk("R5 cache all ones", ba(6, 0), 32'h0000_0101);
    wr(ba(6, 0), 2'd0, 32'h0000_0000);
    rd_chk("R5 R6 cache byte lane 0 clear", ba(6, 0), 32'h0000_0100);
    wr(ba(6, 1), 2'd0, 32'hFFFF_FF00);
    rd_chk("R5 R6 cache byte lane 1 zero", ba(6, 0), 32'h0000_0000);
  endtask

  task automatic t_lanes;
    wr(ba(0, 3), 2'd2, 32'h1122_3344);
    rd_chk("R6 long ignores lane", ba(0, 0), 32'h1122_3344);
    wr(ba(0, 2), 2'd0, 32'hFFFF_FFAB);
    rd_chk("R6 byte lane 2", ba(0, 0), 32'h11AB_3344);
    wr(ba(0, 2), 2'd1, 32'hFFFF_CDEF);
    rd_chk("R6 word lane 2", ba(0, 0), 32'hCDEF_3344);
    wr(ba(0, 3), 2'd0, 32'h0000_0055);
    rd_chk("R6 byte lane 3", ba(0, 0), 32'h55EF_3344);
    wr(ba(0, 0), 2'd1, 32'h0000_9876);
    rd_chk("R6 word lane 0", ba(0, 0), 32'h55EF_9876);
  endtask

  task automatic t_timer;
    wr(ba(7, 0), 2'd2, 32'h1234_FFFF);
    rd_chk("R8 R7 load then read", ba(7, 0), 32'h1239_1239);
    rd_chk("R7 second read", ba(7, 0), 32'h123E_123E);
    wr(ba(7, 0), 2'd0, 32'h0000_00FF);
    rd_chk("R8 low lane write ignored", ba(7, 0), 32'h1243_1243);
    wr(ba(7, 2), 2'd1, 32'h0000_0001);
    rd_chk("R8 word lane 2 load", ba(7, 0), 32'h0006_0006);
    wr(ba(7, 0), 2'd2, 32'hFFFE_0000);
    rd_chk("R7 wrap", ba(7, 0), 32'h0003_0003);
  endtask

  task automatic t_unimpl;
    wr(ba(0, 0), 2'd2, 32'h0BAD_F00D);
    wr(ba(1, 0), 2'd2, 32'hFFFF_FFFF);
    wr(ba(3, 0), 2'd2, 32'hFFFF_FFFF);
    rd_chk("R9 offset 1 zero", ba(1, 0), 32'h0);
    rd_chk("R9 offset 3 zero", ba(3, 0), 32'h0);
    rd_chk("R9 halt untouched", ba(0, 0), 32'h0BAD_F00D);
    rd_chk("R9 mapbase untouched", ba(2, 0), 32'h0012_3000);
    rd_chk("R9 display untouched", ba(4, 0), 32'hA5A5_5A5A);
  endtask

  task automatic t_collision;
    @(negedge clk);
    addr = ba(7, 0); size = 2'd2; wdata = 32'h0100_0000; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R2 no valid on write+read", {31'b0, rd_valid}, 32'h0);
    @(negedge clk);
    check("R2 valid one cycle only", {31'b0, rd_valid}, 32'h0);
    rd_chk("R2 write won, no advance", ba(7, 0), 32'h0105_0105);
  endtask

  task automatic t_rereset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_chk("R1 halt after reset", ba(0, 0), 32'h0);
    rd_chk("R1 parity after reset", ba(5, 0), 32'h0000_00F0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; size = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_parity();
    t_cache();
    t_lanes();
    t_timer();
    t_unimpl();
    t_collision();
    t_rereset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule